// File: doc/BRIEF.md
# Display Controller Register Interface

This block is the register slave of an indexed-colour display controller. A 32-bit request bus, with one request per cycle, reaches a 2 MiB offset window. Inside that window the block decodes a fixed identifier, three scalar registers and three arrays:

- **Scalar registers:** control, top-of-screen and cursor position.
- **Arrays:** a 256-entry colour lookup table, a three-entry cursor colour table and a 512-entry cursor pattern.

Each array entry takes one 8-byte slot. Colour entries hold 24-bit packed RGB.

Accesses may be byte, halfword or word wide. A narrow write is built by merging the addressed lane into the word that is currently stored, and the merged word is written back. A read returns its data one cycle after the request. Writes to the video timing registers complete but store nothing.

The pixel pipeline sits outside this block. It reads the colour, cursor colour and pattern arrays through three combinational lookup ports. It uses the control register and its decoded depth, blank and cursor-disable fields. It pulses a frame-completion strobe, which raises the display interrupt. Any bus write lowers that interrupt again.

Top module: `dispctl_regif`

## Requirements
- R1: A word read at offset 0x000000 returns 0x00000010. A write there leaves later reads unchanged.
- R2: Colour entries sit at offsets 0x080800 to 0x080FFF. The entry index is (offset-0x080800)>>3, so offset+4 reaches the same entry. Each entry stores bits 23:0 of the written word: red in 23:16, green in 15:8, blue in 7:0. A read returns the entry with bits 31:24 zero. `clut_rgb_o` shows the entry selected by `clut_idx_i`.
- R3: Cursor colour entries 0 to 2 sit at offsets 0x080508, 0x080510 and 0x080518, in the same RGB packing. They are read through `cpal_idx_i`/`cpal_rgb_o`, and index 3 reads zero.
- R4: Cursor pattern entries sit at offsets 0x081000 to 0x081FFF with index (offset-0x081000)>>3. Each entry keeps bits 15:0 of the written word, and reads return it zero-extended. `cpat_bits_o` shows entry `cpat_idx_i`.
- R5: Control (0x080300), top-of-screen (0x080400) and cursor position (0x080638) store full 32-bit words. They read back and drive `ctrl_o`, `top_o` and `cursor_pos_o`.
- R6: `depth_o` decodes control bits 22:20 as 0→1, 1→2, 2→4, 3→8, 4→15, 5→16, 6 and 7→0. `force_blank_o` is control bit 10 and `cursor_off_o` is control bit 23. All three follow the stored control word.
- R7: Writes to the timing offsets 0x080000, 0x080108 to 0x080170 at an 8-byte step, 0x080200 and 0x180000 change no state. Reads there return zero.
- R8: Any other offset reads zero and ignores writes.
- R9: `req_size_i` encodes 0 as byte, 1 as halfword and 2 or 3 as word. A byte write replaces lane addr[1:0] with wdata[7:0]. A halfword write replaces bits 31:16 if addr[1] is set, otherwise bits 15:0, with wdata[15:0]. All other bits of the stored word are kept.
- R10: A byte read returns (word>>8*addr[1:0])&0xFF. A halfword read returns word[31:16] if addr[1] is set, otherwise word[15:0], zero-extended.
- R11: `rsp_valid_o` is high in exactly the cycle after a read request is accepted, and `rsp_rdata_o` holds that read's data.
- R12: A `frame_done_i` pulse sets `irq_o` on the next cycle. Any accepted write clears it on the next cycle, and the write wins when both occur in the same cycle. Otherwise `irq_o` holds.
- R13: After reset, all registers and array entries are zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request accepted this cycle |
| req_write_i | input | 1 | 1 write, 0 read |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr_i | input | ADDR_W | Byte offset within the window |
| req_wdata_i | input | 32 | Write data, narrow data in low bits |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| frame_done_i | input | 1 | Frame completed strobe |
| irq_o | output | 1 | Display interrupt |
| ctrl_o | output | 32 | Control word |
| top_o | output | 32 | Top-of-screen word |
| cursor_pos_o | output | 32 | Cursor position word |
| depth_o | output | 5 | Decoded pixel depth in bits |
| force_blank_o | output | 1 | Blank the display |
| cursor_off_o | output | 1 | Cursor disabled |
| clut_idx_i | input | 8 | Colour table lookup index |
| clut_rgb_o | output | 24 | Colour table entry |
| cpal_idx_i | input | 2 | Cursor colour lookup index |
| cpal_rgb_o | output | 24 | Cursor colour entry |
| cpat_idx_i | input | 9 | Cursor pattern lookup index |
| cpat_bits_o | output | 16 | Cursor pattern entry |

## Verification
Every colour and pattern entry is written with data that depends on its index and is read back both over the bus and through the lookup port. This separates index-bit and stride errors from storage errors, and the +4 alias writes confirm that offset bit 2 is ignored. Narrow writes put a distinct value in each lane and are checked against an arithmetic merge, which exposes wrong lane selection or lost neighbour bits. Narrow reads sweep every lane of a known word. Timing, unmapped and identifier writes are followed by readback of the neighbouring state, so a stray store shows up. All eight depth codes are applied together with the blank and cursor-disable bits. The interrupt is driven by strobe alone, by write alone and by both in the same cycle.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_WORD2 = 2'd3
   } acc_size_e;

   typedef enum logic [3:0] {
      RGN_NONE,
      RGN_ID,
      RGN_CTRL,
      RGN_TOP,
      RGN_CPOS,
      RGN_CLUT,
      RGN_CPAL,
      RGN_CPAT,
      RGN_SINK
   } region_e;

   localparam int          BUS_W     = 32;
   localparam int          RGB_W     = 24;
   localparam int          SLOT_W    = 9;
   localparam int          MIN_ADDR_W = 21;
   localparam logic [31:0] ID_VALUE  = 32'h0000_0010;

   localparam logic [31:0] OFS_ID     = 32'h0000_0000;
   localparam logic [31:0] OFS_CTRL   = 32'h0008_0300;
   localparam logic [31:0] OFS_TOP    = 32'h0008_0400;
   localparam logic [31:0] OFS_CPOS   = 32'h0008_0638;
   localparam logic [31:0] OFS_CLUT   = 32'h0008_0800;
   localparam logic [31:0] LEN_CLUT   = 32'h0000_0800;
   localparam logic [31:0] OFS_CPAT   = 32'h0008_1000;
   localparam logic [31:0] LEN_CPAT   = 32'h0000_1000;
   localparam logic [31:0] OFS_CPAL   = 32'h0008_0508;
   localparam logic [31:0] LEN_CPAL   = 32'h0000_0018;
   localparam logic [31:0] OFS_TIM_LO = 32'h0008_0108;
   localparam logic [31:0] OFS_TIM_HI = 32'h0008_0170;
   localparam logic [31:0] OFS_BOOT   = 32'h0008_0000;
   localparam logic [31:0] OFS_VMASK  = 32'h0008_0200;
   localparam logic [31:0] OFS_SOFTRST = 32'h0018_0000;

   function automatic logic [4:0] depth_of(input logic [2:0] code);
      logic [4:0] d;
      case (code)
         3'd0:    d = 5'd1;
         3'd1:    d = 5'd2;
         3'd2:    d = 5'd4;
         3'd3:    d = 5'd8;
         3'd4:    d = 5'd15;
         3'd5:    d = 5'd16;
         default: d = 5'd0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/dispctl_addr_dec.sv
module dispctl_addr_dec
   import dispctl_pkg::*;
#(
   parameter int ADDR_W = 21
) (
   input  logic [ADDR_W-1:0] addr_i,
   output region_e           rgn_o,
   output logic [SLOT_W-1:0] slot_o
);

   logic [31:0] word_ofs;
   logic        in_timing;

   always_comb begin
      word_ofs  = 32'(addr_i) & ~32'h3;
      in_timing = (word_ofs >= OFS_TIM_LO) && (word_ofs <= OFS_TIM_HI) &&
                  (word_ofs[2:0] == 3'b000);
   end

   always_comb begin
      rgn_o  = RGN_NONE;
      slot_o = '0;
      if (word_ofs == OFS_ID) begin
         rgn_o = RGN_ID;
      end else if (word_ofs == OFS_CTRL) begin
         rgn_o = RGN_CTRL;
      end else if (word_ofs == OFS_TOP) begin
         rgn_o = RGN_TOP;
      end else if (word_ofs == OFS_CPOS) begin
         rgn_o = RGN_CPOS;
      end else if (word_ofs >= OFS_CLUT && word_ofs < OFS_CLUT + LEN_CLUT) begin
         rgn_o  = RGN_CLUT;
         slot_o = SLOT_W'((word_ofs - OFS_CLUT) >> 3);
      end else if (word_ofs >= OFS_CPAT && word_ofs < OFS_CPAT + LEN_CPAT) begin
         rgn_o  = RGN_CPAT;
         slot_o = SLOT_W'((word_ofs - OFS_CPAT) >> 3);
      end else if (word_ofs >= OFS_CPAL && word_ofs < OFS_CPAL + LEN_CPAL) begin
         rgn_o  = RGN_CPAL;
         slot_o = SLOT_W'((word_ofs - OFS_CPAL) >> 3);
      end else if (in_timing || word_ofs == OFS_BOOT || word_ofs == OFS_VMASK ||
                   word_ofs == OFS_SOFTRST) begin
         rgn_o = RGN_SINK;
      end
   end

endmodule

// File: rtl/dispctl_lane_unit.sv
module dispctl_lane_unit
   import dispctl_pkg::*;
(
   input  acc_size_e        size_i,
   input  logic [1:0]       lane_i,
   input  logic [BUS_W-1:0] old_i,
   input  logic [BUS_W-1:0] new_i,
   output logic [BUS_W-1:0] merged_o,
   output logic [BUS_W-1:0] extract_o
);

   localparam int LANES = BUS_W / 8;

   logic is_word;
   assign is_word = (size_i == SZ_WORD) || (size_i == SZ_WORD2);

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      localparam logic [1:0] LB = 2'(b);
      logic       en;
      logic [7:0] src;
      always_comb begin
         en = is_word ||
              (size_i == SZ_HALF && lane_i[1] == LB[1]) ||
              (size_i == SZ_BYTE && lane_i == LB);
         if (is_word)
            src = new_i[8*b +: 8];
         else if (size_i == SZ_HALF)
            src = new_i[8*(b % 2) +: 8];
         else
            src = new_i[7:0];
         merged_o[8*b +: 8] = en ? src : old_i[8*b +: 8];
      end
   end

   always_comb begin
      case (size_i)
         SZ_BYTE: extract_o = BUS_W'(8'(old_i >> (8 * lane_i)));
         SZ_HALF: extract_o = lane_i[1] ? BUS_W'(old_i[31:16]) : BUS_W'(old_i[15:0]);
         default: extract_o = old_i;
      endcase
   end

endmodule

// File: rtl/dispctl_entry_array.sv
module dispctl_entry_array #(
   parameter int  ENTRIES = 256,
   parameter int  DATA_W  = 24,
   localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  widx_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [IDX_W-1:0]  ridx_a_i,
   output logic [DATA_W-1:0] rdata_a_o,
   input  logic [IDX_W-1:0]  ridx_b_i,
   output logic [DATA_W-1:0] rdata_b_o
);

   logic [DATA_W-1:0] mem_q [ENTRIES];
   logic              ok_w, ok_a, ok_b;

   if (ENTRIES == (1 << IDX_W)) begin : g_full
      assign ok_w = 1'b1;
      assign ok_a = 1'b1;
      assign ok_b = 1'b1;
   end else begin : g_partial
      localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
      assign ok_w = (widx_i   <= LAST);
      assign ok_a = (ridx_a_i <= LAST);
      assign ok_b = (ridx_b_i <= LAST);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int k = 0; k < ENTRIES; k++) mem_q[k] <= '0;
      end else if (we_i && ok_w) begin
         mem_q[widx_i] <= wdata_i;
      end
   end

   assign rdata_a_o = ok_a ? mem_q[ridx_a_i] : '0;
   assign rdata_b_o = ok_b ? mem_q[ridx_b_i] : '0;

endmodule

// File: rtl/dispctl_regif.sv
module dispctl_regif
   import dispctl_pkg::*;
#(
   parameter int ADDR_W       = 21,
   parameter int CLUT_ENTRIES = 256,
   parameter int CPAL_ENTRIES = 3,
   parameter int CPAT_ENTRIES = 512,
   parameter int CPAT_W       = 16,
   localparam int CLUT_IW     = $clog2(CLUT_ENTRIES),
   localparam int CPAL_IW     = $clog2(CPAL_ENTRIES),
   localparam int CPAT_IW     = $clog2(CPAT_ENTRIES)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               req_valid_i,
   input  logic               req_write_i,
   input  logic [1:0]         req_size_i,
   input  logic [ADDR_W-1:0]  req_addr_i,
   input  logic [BUS_W-1:0]   req_wdata_i,
   output logic               rsp_valid_o,
   output logic [BUS_W-1:0]   rsp_rdata_o,
   input  logic               frame_done_i,
   output logic               irq_o,
   output logic [BUS_W-1:0]   ctrl_o,
   output logic [BUS_W-1:0]   top_o,
   output logic [BUS_W-1:0]   cursor_pos_o,
   output logic [4:0]         depth_o,
   output logic               force_blank_o,
   output logic               cursor_off_o,
   input  logic [CLUT_IW-1:0] clut_idx_i,
   output logic [RGB_W-1:0]   clut_rgb_o,
   input  logic [CPAL_IW-1:0] cpal_idx_i,
   output logic [RGB_W-1:0]   cpal_rgb_o,
   input  logic [CPAT_IW-1:0] cpat_idx_i,
   output logic [CPAT_W-1:0]  cpat_bits_o
);

   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("ADDR_W must cover the 2 MiB window");
   end
   if (CLUT_ENTRIES > 256 || CLUT_ENTRIES < 2) begin : g_bad_clut
      $error("CLUT_ENTRIES must be 2..256");
   end
   if (CPAT_ENTRIES > 512 || CPAT_ENTRIES < 2) begin : g_bad_cpat
      $error("CPAT_ENTRIES must be 2..512");
   end
   if (CPAL_ENTRIES != 3) begin : g_bad_cpal
      $error("CPAL_ENTRIES must be 3 to fit the 24-byte slot range");
   end
   if (CPAT_W < 1 || CPAT_W > BUS_W) begin : g_bad_cpat_w
      $error("CPAT_W must be 1..32");
   end

   // ---------------- decode ----------------
   region_e           rgn;
   logic [SLOT_W-1:0] slot;
   acc_size_e         size;
   logic              wr_hit, rd_hit;

   assign size   = acc_size_e'(req_size_i);
   assign wr_hit = req_valid_i && req_write_i;
   assign rd_hit = req_valid_i && !req_write_i;

   dispctl_addr_dec #(.ADDR_W(ADDR_W)) dec_i (
      .addr_i (req_addr_i),
      .rgn_o  (rgn),
      .slot_o (slot)
   );

   // ---------------- storage ----------------
   logic [BUS_W-1:0]  ctrl_q, top_q, cpos_q;
   logic [RGB_W-1:0]  clut_bus_rd, cpal_bus_rd;
   logic [CPAT_W-1:0] cpat_bus_rd;
   logic [BUS_W-1:0]  cur_word, merged, extracted;

   dispctl_entry_array #(.ENTRIES(CLUT_ENTRIES), .DATA_W(RGB_W)) clut_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (wr_hit && rgn == RGN_CLUT),
      .widx_i    (CLUT_IW'(slot)),
      .wdata_i   (merged[RGB_W-1:0]),
      .ridx_a_i  (CLUT_IW'(slot)),
      .rdata_a_o (clut_bus_rd),
      .ridx_b_i  (clut_idx_i),
      .rdata_b_o (clut_rgb_o)
   );

   dispctl_entry_array #(.ENTRIES(CPAL_ENTRIES), .DATA_W(RGB_W)) cpal_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (wr_hit && rgn == RGN_CPAL),
      .widx_i    (CPAL_IW'(slot)),
      .wdata_i   (merged[RGB_W-1:0]),
      .ridx_a_i  (CPAL_IW'(slot)),
      .rdata_a_o (cpal_bus_rd),
      .ridx_b_i  (cpal_idx_i),
      .rdata_b_o (cpal_rgb_o)
   );

   dispctl_entry_array #(.ENTRIES(CPAT_ENTRIES), .DATA_W(CPAT_W)) cpat_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (wr_hit && rgn == RGN_CPAT),
      .widx_i    (CPAT_IW'(slot)),
      .wdata_i   (merged[CPAT_W-1:0]),
      .ridx_a_i  (CPAT_IW'(slot)),
      .rdata_a_o (cpat_bus_rd),
      .ridx_b_i  (cpat_idx_i),
      .rdata_b_o (cpat_bits_o)
   );

   // ---------------- current word and lane handling ----------------
   always_comb begin
      case (rgn)
         RGN_ID:   cur_word = ID_VALUE;
         RGN_CTRL: cur_word = ctrl_q;
         RGN_TOP:  cur_word = top_q;
         RGN_CPOS: cur_word = cpos_q;
         RGN_CLUT: cur_word = BUS_W'(clut_bus_rd);
         RGN_CPAL: cur_word = BUS_W'(cpal_bus_rd);
         RGN_CPAT: cur_word = BUS_W'(cpat_bus_rd);
         default:  cur_word = '0;
      endcase
   end

   dispctl_lane_unit lane_i (
      .size_i    (size),
      .lane_i    (req_addr_i[1:0]),
      .old_i     (cur_word),
      .new_i     (req_wdata_i),
      .merged_o  (merged),
      .extract_o (extracted)
   );

   // ---------------- scalar registers ----------------
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
         top_q  <= '0;
         cpos_q <= '0;
      end else if (wr_hit) begin
         if (rgn == RGN_CTRL) ctrl_q <= merged;
         if (rgn == RGN_TOP)  top_q  <= merged;
         if (rgn == RGN_CPOS) cpos_q <= merged;
      end
   end

   // ---------------- read response ----------------
   logic             rsp_valid_q;
   logic [BUS_W-1:0] rsp_rdata_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_valid_q <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         rsp_valid_q <= rd_hit;
         if (rd_hit) rsp_rdata_q <= extracted;
      end
   end

   // ---------------- interrupt ----------------
   logic irq_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           irq_q <= 1'b0;
      else if (wr_hit)       irq_q <= 1'b0;
      else if (frame_done_i) irq_q <= 1'b1;
   end

   // ---------------- outputs ----------------
   assign rsp_valid_o   = rsp_valid_q;
   assign rsp_rdata_o   = rsp_rdata_q;
   assign irq_o         = irq_q;
   assign ctrl_o        = ctrl_q;
   assign top_o         = top_q;
   assign cursor_pos_o  = cpos_q;
   assign depth_o       = depth_of(ctrl_q[22:20]);
   assign force_blank_o = ctrl_q[10];
   assign cursor_off_o  = ctrl_q[23];

endmodule

// File: rtl/dispctl_regif_chk.sv
module dispctl_regif_chk #(
   parameter int ADDR_W = 21
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              req_valid_i,
   input logic              req_write_i,
   input logic [1:0]        req_size_i,
   input logic [ADDR_W-1:0] req_addr_i,
   input logic [31:0]       req_wdata_i,
   input logic              rsp_valid_o,
   input logic [31:0]       rsp_rdata_o,
   input logic              frame_done_i,
   input logic              irq_o,
   input logic [31:0]       ctrl_o
);

   logic wr, rd, is_word;
   assign wr      = req_valid_i && req_write_i;
   assign rd      = req_valid_i && !req_write_i;
   assign is_word = req_size_i[1];

   // R12
   irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr |=> !irq_o);

   // R12
   irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_done_i && !wr) |=> irq_o);

   // R12
   irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!frame_done_i && !wr) |=> $stable(irq_o));

   // R11
   rsp_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd |=> rsp_valid_o);

   // R11
   rsp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd |=> !rsp_valid_o);

   // R1
   id_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd && is_word && req_addr_i[ADDR_W-1:2] == '0) |=> rsp_rdata_o == 32'h10);

   // R10
   byte_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd && req_size_i == 2'd0) |=> rsp_rdata_o[31:8] == 24'h0);

   // R5
   ctrl_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && is_word && 32'(req_addr_i) == 32'h0008_0300) |=> ctrl_o == $past(req_wdata_i));

endmodule

bind dispctl_regif dispctl_regif_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .req_valid_i  (req_valid_i),
   .req_write_i  (req_write_i),
   .req_size_i   (req_size_i),
   .req_addr_i   (req_addr_i),
   .req_wdata_i  (req_wdata_i),
   .rsp_valid_o  (rsp_valid_o),
   .rsp_rdata_o  (rsp_rdata_o),
   .frame_done_i (frame_done_i),
   .irq_o        (irq_o),
   .ctrl_o       (ctrl_o)
);

// File: tb/dispctl_regif_tb_top.sv
`timescale 1ns/1ps
module dispctl_regif_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_size = 2'd2;
   logic [20:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        frame_done = 1'b0;
   logic        irq;
   logic [31:0] ctrl, top, cpos;
   logic [4:0]  depth;
   logic        blank, curs_off;
   logic [7:0]  clut_idx = '0;
   logic [23:0] clut_rgb;
   logic [1:0]  cpal_idx = '0;
   logic [23:0] cpal_rgb;
   logic [8:0]  cpat_idx = '0;
   logic [15:0] cpat_bits;

   int vectors = 0;
   int miscompares = 0;

   always #4 clk = ~clk;

   dispctl_regif dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .req_valid_i(req_valid), .req_write_i(req_write), .req_size_i(req_size),
      .req_addr_i(req_addr), .req_wdata_i(req_wdata),
      .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
      .frame_done_i(frame_done), .irq_o(irq),
      .ctrl_o(ctrl), .top_o(top), .cursor_pos_o(cpos), .depth_o(depth),
      .force_blank_o(blank), .cursor_off_o(curs_off),
      .clut_idx_i(clut_idx), .clut_rgb_o(clut_rgb),
      .cpal_idx_i(cpal_idx), .cpal_rgb_o(cpal_rgb),
      .cpat_idx_i(cpat_idx), .cpat_bits_o(cpat_bits)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic [1:0] sz, input logic [20:0] a,
                         input logic [31:0] d, output logic [31:0] q);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
      @(negedge clk);
      q = rsp_rdata;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic wr(input logic [1:0] sz, input logic [20:0] a, input logic [31:0] d);
      logic [31:0] q;
      access(1'b1, sz, a, d, q);
   endtask

   task automatic rd(input logic [1:0] sz, input logic [20:0] a, output logic [31:0] q);
      access(1'b0, sz, a, 32'h0, q);
   endtask

   function automatic logic [23:0] clut_val(input int i);
      return 24'((i * 32'h0001_0203) + 32'h0011_2233);
   endfunction

   function automatic logic [31:0] cpat_val(input int i);
      return (i * 32'h0003_0507) ^ 32'hA5A5_5A5A;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [31:0] q, exp;
      int dtab [8] = '{1, 2, 4, 8, 15, 16, 0, 0};
      logic [20:0] sinks [6] = '{21'h080000, 21'h080108, 21'h080150, 21'h080170,
                                 21'h080200, 21'h180000};
      logic [20:0] holes [6] = '{21'h080304, 21'h080500, 21'h080520, 21'h080004,
                                 21'h1FFFFC, 21'h082000};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R13 reset state
      @(negedge clk);
      check("R13 irq", 32'(irq), 32'h0);
      rd(2'd2, 21'h080300, q); check("R13 ctrl", q, 32'h0);
      rd(2'd2, 21'h080400, q); check("R13 top", q, 32'h0);
      rd(2'd2, 21'h080638, q); check("R13 cpos", q, 32'h0);
      rd(2'd2, 21'h080800, q); check("R13 clut0", q, 32'h0);
      rd(2'd2, 21'h081FF8, q); check("R13 cpat511", q, 32'h0);

      // R1 identifier
      rd(2'd2, 21'h000000, q); check("R1 id", q, 32'h10);
      wr(2'd2, 21'h000000, 32'hFFFF_FFFF);
      rd(2'd2, 21'h000000, q); check("R1 id after write", q, 32'h10);

      // R11 response timing
      rd(2'd2, 21'h000000, q);
      check("R11 valid after read", 32'(rsp_valid), 32'h1);
      @(negedge clk);
      check("R11 valid idle", 32'(rsp_valid), 32'h0);
      wr(2'd2, 21'h080400, 32'h0);
      check("R11 valid after write", 32'(rsp_valid), 32'h0);

      // R2 colour table sweep, every 4th entry through the +4 alias
      for (int i = 0; i < 256; i++)
         wr(2'd2, 21'h080800 + 21'(8*i) + ((i % 4 == 1) ? 21'd4 : 21'd0),
            {8'hC3, clut_val(i)});
      for (int i = 0; i < 256; i++) begin
         rd(2'd2, 21'h080800 + 21'(8*i), q);
         check("R2 clut read", q, {8'h0, clut_val(i)});
         clut_idx = 8'(i); #1;
         check("R2 clut lookup", 32'(clut_rgb), 32'(clut_val(i)));
      end

      // R4 cursor pattern sweep
      for (int i = 0; i < 512; i++)
         wr(2'd2, 21'h081000 + 21'(8*i), cpat_val(i));
      for (int i = 0; i < 512; i++) begin
         rd(2'd2, 21'h081000 + 21'(8*i), q);
         check("R4 cpat read", q, {16'h0, cpat_val(i)[15:0]});
         cpat_idx = 9'(i); #1;
         check("R4 cpat lookup", 32'(cpat_bits), 32'(cpat_val(i)[15:0]));
      end

      // R3 cursor colours
      for (int i = 0; i < 3; i++)
         wr(2'd2, 21'h080508 + 21'(8*i), 32'hEE00_0000 | (32'h10_2030 * (i + 1)));
      for (int i = 0; i < 4; i++) begin
         if (i < 3) begin
            rd(2'd2, 21'h080508 + 21'(8*i), q);
            check("R3 cpal read", q, 32'h10_2030 * (i + 1));
         end
         cpal_idx = 2'(i); #1;
         check("R3 cpal lookup", 32'(cpal_rgb), (i < 3) ? 32'h10_2030 * (i + 1) : 32'h0);
      end

      // R5 scalar registers
      wr(2'd2, 21'h080300, 32'h1234_5678);
      wr(2'd2, 21'h080400, 32'h8765_4321);
      wr(2'd2, 21'h080638, 32'h0040_0123);
      rd(2'd2, 21'h080300, q); check("R5 ctrl read", q, 32'h1234_5678);
      rd(2'd2, 21'h080400, q); check("R5 top read", q, 32'h8765_4321);
      rd(2'd2, 21'h080638, q); check("R5 cpos read", q, 32'h0040_0123);
      check("R5 top port", top, 32'h8765_4321);
      check("R5 cpos port", cpos, 32'h0040_0123);

      // R6 depth and flag decode
      for (int c = 0; c < 8; c++) begin
         exp = (32'(c) << 20) | ((c % 2 == 1) ? 32'h400 : 32'h0) |
               ((c >= 4) ? 32'h0080_0000 : 32'h0);
         wr(2'd2, 21'h080300, exp);
         check("R6 depth", 32'(depth), 32'(dtab[c]));
         check("R6 blank", 32'(blank), 32'(c % 2));
         check("R6 cursor off", 32'(curs_off), (c >= 4) ? 32'h1 : 32'h0);
         check("R6 ctrl port", ctrl, exp);
      end

      // R7 timing offsets discard writes
      wr(2'd2, 21'h080300, 32'hCAFE_0001);
      for (int i = 0; i < 6; i++) begin
         wr(2'd2, sinks[i], 32'hDEAD_BEEF);
         rd(2'd2, sinks[i], q); check("R7 timing read", q, 32'h0);
      end
      rd(2'd2, 21'h080300, q); check("R7 ctrl kept", q, 32'hCAFE_0001);
      rd(2'd2, 21'h080400, q); check("R7 top kept", q, 32'h8765_4321);

      // R8 unmapped offsets
      for (int i = 0; i < 6; i++) begin
         wr(2'd2, holes[i], 32'h5555_AAAA);
         rd(2'd2, holes[i], q); check("R8 hole read", q, 32'h0);
      end
      rd(2'd2, 21'h080300, q); check("R8 ctrl kept", q, 32'hCAFE_0001);
      rd(2'd2, 21'h080518, q); check("R8 cpal2 kept", q, 32'h30_6090);
      rd(2'd2, 21'h080638, q); check("R8 cpos kept", q, 32'h0040_0123);

      // R9 narrow writes on top-of-screen
      exp = 32'h8765_4321;
      for (int l = 0; l < 4; l++) begin
         wr(2'd0, 21'h080400 + 21'(l), 32'hFFFF_FF00 | 32'(8'h90 + l));
         exp = (exp & ~(32'hFF << (8*l))) | (32'(8'h90 + l) << (8*l));
         rd(2'd2, 21'h080400, q); check("R9 byte write", q, exp);
      end
      for (int h = 0; h < 2; h++) begin
         wr(2'd1, 21'h080400 + 21'(2*h), 32'hFFFF_0000 | 32'(16'hB00 + h));
         exp = (exp & ~(32'hFFFF << (16*h))) | (32'(16'hB00 + h) << (16*h));
         rd(2'd2, 21'h080400, q); check("R9 half write", q, exp);
      end
      wr(2'd0, 21'h081003, 32'h77);
      rd(2'd2, 21'h081000, q); check("R9 cpat lane3 dropped", q, {16'h0, cpat_val(0)[15:0]});
      wr(2'd0, 21'h080801, 32'h5C);
      exp = {8'h0, clut_val(0)[23:16], 8'h5C, clut_val(0)[7:0]};
      rd(2'd2, 21'h080800, q); check("R9 clut byte merge", q, exp);

      // R10 narrow reads
      wr(2'd2, 21'h080638, 32'hA1B2_C3D4);
      for (int l = 0; l < 4; l++) begin
         rd(2'd0, 21'h080638 + 21'(l), q);
         check("R10 byte read", q, (32'hA1B2_C3D4 >> (8*l)) & 32'hFF);
      end
      for (int h = 0; h < 2; h++) begin
         rd(2'd1, 21'h080638 + 21'(2*h), q);
         check("R10 half read", q, (32'hA1B2_C3D4 >> (16*h)) & 32'hFFFF);
      end
      rd(2'd0, 21'h000001, q); check("R10 id byte1", q, 32'h0);

      // R12 interrupt
      @(negedge clk); frame_done = 1'b1;
      @(negedge clk); frame_done = 1'b0;
      check("R12 irq set", 32'(irq), 32'h1);
      repeat (3) @(negedge clk);
      check("R12 irq hold", 32'(irq), 32'h1);
      wr(2'd2, 21'h080000, 32'h0);
      check("R12 irq cleared by write", 32'(irq), 32'h0);
      @(negedge clk); frame_done = 1'b1;
      @(negedge clk); frame_done = 1'b0;
      check("R12 irq set again", 32'(irq), 32'h1);
      @(negedge clk);
      frame_done = 1'b1; req_valid = 1'b1; req_write = 1'b1;
      req_size = 2'd2; req_addr = 21'h1FFFFC; req_wdata = 32'h0;
      @(negedge clk);
      frame_done = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      check("R12 write wins", 32'(irq), 32'h0);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule